// File: doc/BRIEF.md
# Ping-Pong Frame Read Address Controller

This block is the read half of a memory master that makes a large external frame store look like a FIFO to a display pipeline. It watches how full a downstream read buffer is. When the buffer has room for a whole transfer, it runs one read transaction made of a fixed number of fixed-length incrementing bursts on the read-address channel. It counts the returning data beats so that only one burst is outstanding at a time. It raises a one-cycle done pulse when the last beat of the transaction has been taken.

Addresses walk through a frame-sized region in one of two banks. When the region is used up, the offset returns to zero. The bank field is then reloaded with the opposite of the bank the writer is filling at that moment. Reads therefore always follow a complete frame, and the two banks give double buffering between writer and reader.

Top module: `pingpong_rd_addr_ctrl`

## Requirements
- R1: During and after reset, with no trigger, arvalid, rready and txn_done are 0 and araddr is 0 (offset 0, bank 00).
- R2: A transaction starts only from idle, and only when buf_wr_count is below BUF_DEPTH-XFER_WORDS (2048-256 = 1792). With a count of 1792 or more, no address is issued.
- R3: Each transaction issues exactly XFER_WORDS/BURST_BEATS (16) accepted addresses. txn_done is high for exactly one cycle, in the cycle after the handshake of the last beat (rlast) of the 16th burst, and is 0 at all other times.
- R4: Once arvalid is high, it stays high and araddr stays unchanged until the cycle in which arready is seen.
- R5: While arvalid is high, arlen is 15 (16 beats), arsize is 3'b010 (4-byte beats) and arburst is 2'b01 (incrementing).
- R6: araddr is {8'h00, bank[1:0], offset[21:0]}. After each accepted address, the offset grows by 64 bytes (one burst) while it is below FRAME_BYTES-64.
- R7: When an address whose offset is FRAME_BYTES-64 or more is accepted, the next offset is 0. The next bank is wr_bank XOR 2'b01, sampled in the cycle of that handshake.
- R8: At most one burst is outstanding: a new arvalid never rises while beats of an earlier burst are still due.
- R9: rready is 1 while a transaction is in progress and 0 once the block has returned to idle.
- R10: A change of wr_bank between wraps has no effect on the bank field of the addresses issued before the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_wr_count | input | 12 | Write-side fill count of the downstream read buffer |
| wr_bank | input | 2 | Bank the writer is currently filling (00 or 01) |
| araddr | output | 32 | Read burst byte address |
| arlen | output | 8 | Burst length minus one |
| arsize | output | 3 | Beat size code |
| arburst | output | 2 | Burst type (incrementing) |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address accepted by the memory side |
| rvalid | input | 1 | Read data beat valid |
| rlast | input | 1 | Last beat of a burst |
| rready | output | 1 | Read data accepted by this side |
| txn_done | output | 1 | One-cycle pulse: whole transaction received |

## Verification
On every cycle, the embedded properties check several rules: the address holds while it waits for acceptance, the start pulse lasts one cycle and is issued only when no burst is in flight, the offset stays burst-aligned and inside the frame, and the bank field changes only on an accepted address. Other behaviour can only be shown by the bench's scenarios. These are the exact address sequence across several frame wraps, with the writer's bank toggling at random moments, and the count of bursts in each transaction. They also include the timing of the done pulse against the final rlast, and the absence of any request while the buffer level sits at or above the trigger limit.

// File: rtl/rdaddr_pkg.sv
package rdaddr_pkg;

    parameter int ADDR_W = 32;
    parameter int BANK_W = 2;
    parameter int OFFS_W = 22;
    parameter int PAD_W  = ADDR_W - BANK_W - OFFS_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic [PAD_W-1:0]  pad;
        logic [BANK_W-1:0] bank;
        logic [OFFS_W-1:0] offs;
    } frame_addr_t;

    // Offset that follows an accepted burst: step forward or wrap to zero.
    function automatic logic [OFFS_W-1:0] next_offset(
        input logic [OFFS_W-1:0] cur,
        input logic [OFFS_W-1:0] limit,
        input logic [OFFS_W-1:0] step
    );
        if (cur < limit) return cur + step;
        return '0;
    endfunction

endpackage

// File: rtl/rd_trigger_fsm.sv
module rd_trigger_fsm
    import rdaddr_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int BUF_DEPTH  = 2048,
    parameter int XFER_WORDS = 256,
    parameter int BURSTS     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] buf_level,
    input  logic             arvalid,
    input  logic             burst_active,
    input  logic             reads_done,
    output logic             start,
    output logic             reading
);
    localparam int ISS_W = $clog2(BURSTS + 1);
    localparam logic [CNT_W-1:0] TRIG_LIMIT = CNT_W'(BUF_DEPTH - XFER_WORDS);
    localparam logic [ISS_W-1:0] ISS_MAX    = ISS_W'(BURSTS);

    rd_state_e        state;
    logic [ISS_W-1:0] issued;

    assign reading = (state == ST_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            start  <= 1'b0;
            issued <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    start  <= 1'b0;
                    issued <= '0;
                    if (buf_level < TRIG_LIMIT) state <= ST_READ;
                end
                ST_READ: begin
                    if (reads_done) begin
                        state <= ST_IDLE;
                        start <= 1'b0;
                    end else if (!arvalid && !burst_active && !start &&
                                 issued < ISS_MAX) begin
                        start  <= 1'b1;
                        issued <= issued + 1'b1;
                    end else begin
                        start <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the start pulse never lasts longer than one cycle
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R8: a burst is launched only when the channel and data path are free
    a_r8_start_when_free: assert property (@(posedge clk) disable iff (rst)
        start |-> (!arvalid && !burst_active));

    // R3: completion returns the controller to idle
    a_r3_done_to_idle: assert property (@(posedge clk) disable iff (rst)
        reads_done |=> !reading);

endmodule

// File: rtl/rd_addr_walker.sv
module rd_addr_walker
    import rdaddr_pkg::*;
#(
    parameter int FRAME_BYTES = 640 * 480 * 4,
    parameter int BURST_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              arready,
    input  logic [BANK_W-1:0] wr_bank,
    output logic              arvalid,
    output frame_addr_t       addr
);
    localparam logic [OFFS_W-1:0] STEP  = OFFS_W'(BURST_BYTES);
    localparam logic [OFFS_W-1:0] LIMIT = OFFS_W'(FRAME_BYTES - BURST_BYTES);
    localparam logic [OFFS_W-1:0] FRAME = OFFS_W'(FRAME_BYTES);
    localparam logic [BANK_W-1:0] FLIP  = BANK_W'(1);

    logic [OFFS_W-1:0] offs;
    logic [BANK_W-1:0] bank;
    logic              accept;

    assign accept = arvalid && arready;
    assign addr   = '{pad: '0, bank: bank, offs: offs};

    always_ff @(posedge clk) begin
        if (rst) begin
            arvalid <= 1'b0;
            offs    <= '0;
            bank    <= '0;
        end else if (start) begin
            arvalid <= 1'b1;
        end else if (accept) begin
            arvalid <= 1'b0;
            offs    <= next_offset(offs, LIMIT, STEP);
            if (offs >= LIMIT) bank <= wr_bank ^ FLIP;
        end
    end

    // R4: a pending request keeps its address until accepted
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (arvalid && !arready) |=> (arvalid && $stable(addr)));

    // R6: offset stays burst-aligned and inside the frame
    a_r6_offset_range: assert property (@(posedge clk) disable iff (rst)
        (offs < FRAME) && ((offs % STEP) == '0));

    // R10: the bank field only moves on an accepted address
    a_r10_bank_stable: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(bank));

endmodule

// File: rtl/rd_beat_counter.sv
module rd_beat_counter #(
    parameter int BURST_BEATS = 16,
    parameter int BURSTS      = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rvalid,
    input  logic rready,
    input  logic rlast,
    output logic burst_active,
    output logic reads_done
);
    localparam int BEAT_W  = $clog2(BURST_BEATS);
    localparam int BURST_W = $clog2(BURSTS);
    localparam logic [BEAT_W-1:0]  LAST_BEAT  = BEAT_W'(BURST_BEATS - 1);
    localparam logic [BURST_W-1:0] LAST_BURST = BURST_W'(BURSTS - 1);

    logic [BEAT_W-1:0]  beat;
    logic [BURST_W-1:0] burst_cnt;
    logic               take;

    assign take = rvalid && rready;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat         <= '0;
            burst_cnt    <= '0;
            burst_active <= 1'b0;
            reads_done   <= 1'b0;
        end else begin
            reads_done <= 1'b0;
            if (start) burst_active <= 1'b1;
            if (take) begin
                if (rlast) begin
                    beat         <= '0;
                    burst_active <= 1'b0;
                    if (burst_cnt == LAST_BURST) begin
                        burst_cnt  <= '0;
                        reads_done <= 1'b1;
                    end else begin
                        burst_cnt <= burst_cnt + 1'b1;
                    end
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

    // R3: the last beat flag lines up with the burst length
    a_r3_last_beat: assert property (@(posedge clk) disable iff (rst)
        (take && rlast) |-> (beat == LAST_BEAT));

    // R8: data beats arrive only for a launched burst
    a_r8_beats_in_burst: assert property (@(posedge clk) disable iff (rst)
        take |-> burst_active);

    // R3: done is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        reads_done |=> !reads_done);

endmodule

// File: rtl/pingpong_rd_addr_ctrl.sv
module pingpong_rd_addr_ctrl
    import rdaddr_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int BUF_DEPTH   = 2048,
    parameter int XFER_WORDS  = 256,
    parameter int BEAT_BYTES  = 4,
    parameter int BURST_BEATS = 16,
    parameter int FRAME_BYTES = 640 * 480 * 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  buf_wr_count,
    input  logic [BANK_W-1:0] wr_bank,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    output logic              arvalid,
    input  logic              arready,
    input  logic              rvalid,
    input  logic              rlast,
    output logic              rready,
    output logic              txn_done
);
    localparam int BURST_BYTES = BEAT_BYTES * BURST_BEATS;
    localparam int BURSTS      = XFER_WORDS / BURST_BEATS;

    logic        start;
    logic        reading;
    logic        burst_active;
    logic        reads_done;
    frame_addr_t addr;

    rd_trigger_fsm #(
        .CNT_W(CNT_W), .BUF_DEPTH(BUF_DEPTH),
        .XFER_WORDS(XFER_WORDS), .BURSTS(BURSTS)
    ) u_fsm (
        .clk(clk), .rst(rst), .buf_level(buf_wr_count),
        .arvalid(arvalid), .burst_active(burst_active),
        .reads_done(reads_done), .start(start), .reading(reading)
    );

    rd_addr_walker #(
        .FRAME_BYTES(FRAME_BYTES), .BURST_BYTES(BURST_BYTES)
    ) u_walk (
        .clk(clk), .rst(rst), .start(start), .arready(arready),
        .wr_bank(wr_bank), .arvalid(arvalid), .addr(addr)
    );

    rd_beat_counter #(
        .BURST_BEATS(BURST_BEATS), .BURSTS(BURSTS)
    ) u_beats (
        .clk(clk), .rst(rst), .start(start), .rvalid(rvalid),
        .rready(rready), .rlast(rlast),
        .burst_active(burst_active), .reads_done(reads_done)
    );

    assign araddr   = addr;
    assign arlen    = 8'(BURST_BEATS - 1);
    assign arsize   = 3'($clog2(BEAT_BYTES));
    assign arburst  = 2'b01;
    assign rready   = reading;
    assign txn_done = reads_done;

    // R9: data is accepted only inside a transaction
    a_r9_rready_idle: assert property (@(posedge clk) disable iff (rst)
        txn_done |=> !rready);

endmodule

// File: tb/sim_pingpong_rd_addr_ctrl.sv
module sim_pingpong_rd_addr_ctrl;
    localparam int FRAME = 1600;
    localparam int BURST = 64;
    localparam int NTX   = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] buf_wr_count = 12'd1792;
    logic [1:0]  wr_bank = 2'b00;
    logic [31:0] araddr;
    logic [7:0]  arlen;
    logic [2:0]  arsize;
    logic [1:0]  arburst;
    logic        arvalid, rready, txn_done;
    logic        arready = 1'b0, rvalid = 1'b0, rlast = 1'b0;

    int checks = 0, fails = 0;
    int ar_total = 0, ar_in_txn = 0, bursts_done = 0, beats_left = 0;
    bit slave_on = 0, expect_done = 0, prev_wait = 0, prev_valid = 0;
    logic [31:0] prev_addr = '0;
    int exp_off = 0;
    logic [1:0] exp_bank = 2'b00;
    bit just_wrapped = 0;

    always #10 clk = ~clk;

    pingpong_rd_addr_ctrl #(.FRAME_BYTES(FRAME)) u0 (
        .clk(clk), .rst(rst), .buf_wr_count(buf_wr_count), .wr_bank(wr_bank),
        .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .arvalid(arvalid), .arready(arready), .rvalid(rvalid), .rlast(rlast),
        .rready(rready), .txn_done(txn_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [1:0] b, input int off);
        return {8'h00, b, 22'(off)};
    endfunction

    // memory-side model, all driving at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (slave_on) begin
                check(txn_done == expect_done, "R3 done timing", txn_done, expect_done);
                if (expect_done) begin
                    check(ar_in_txn == 16, "R3 bursts per transaction", ar_in_txn, 16);
                    ar_in_txn = 0;
                end
                expect_done = 0;
                if (prev_wait) begin
                    check(arvalid == 1'b1, "R4 valid held", arvalid, 1);
                    check(araddr == prev_addr, "R4 address held", araddr, prev_addr);
                end
                if (arvalid && !prev_valid)
                    check(beats_left == 0, "R8 one outstanding", beats_left, 0);
                if (beats_left > 0) begin
                    check(rready == 1'b1, "R9 rready in transaction", rready, 1);
                    rvalid = ($urandom % 4) != 0;
                    rlast  = rvalid && (beats_left == 1);
                    if (rvalid) begin
                        beats_left--;
                        if (rlast) begin
                            bursts_done++;
                            if (bursts_done % 16 == 0) expect_done = 1;
                        end
                    end
                end else begin
                    rvalid = 0;
                    rlast  = 0;
                end
                if ($urandom % 20 == 0) wr_bank = {1'b0, ~wr_bank[0]};
                arready = ($urandom % 3) != 0;
                if (arvalid && arready) begin
                    check(araddr == exp_addr(exp_bank, exp_off),
                          just_wrapped ? "R7 wrap address" : "R6 R10 address",
                          araddr, exp_addr(exp_bank, exp_off));
                    check(arlen == 8'd15 && arsize == 3'b010 && arburst == 2'b01,
                          "R5 burst fields", {arlen, arsize, arburst}, {8'd15, 3'b010, 2'b01});
                    if (exp_off < FRAME - BURST) begin
                        exp_off += BURST;
                        just_wrapped = 0;
                    end else begin
                        exp_off = 0;
                        exp_bank = wr_bank ^ 2'b01;
                        just_wrapped = 1;
                    end
                    beats_left = 16;
                    ar_total++;
                    ar_in_txn++;
                end
                prev_wait  = arvalid && !arready;
                prev_valid = arvalid;
                prev_addr  = araddr;
            end
        end
    end

    initial begin
        int base;
        bit hung;
        void'($urandom(32'd2024));
        hung = 0;
        repeat (4) @(negedge clk);
        check(arvalid == 0 && rready == 0 && txn_done == 0, "R1 reset outputs",
              {arvalid, rready, txn_done}, 0);
        check(araddr == 32'h0, "R1 reset address", araddr, 0);
        rst = 1'b0;
        slave_on = 1;
        repeat (150) @(negedge clk);
        check(ar_total == 0, "R2 no start at 1792", ar_total, 0);
        check(araddr == 32'h0 && rready == 0, "R1 idle after reset", araddr, 0);
        for (int t = 0; t < NTX && !hung; t++) begin
            int n;
            buf_wr_count = (t == 0) ? 12'd1791 : 12'($urandom_range(0, 1791));
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!txn_done && n < 5000);
            if (!txn_done) begin
                hung = 1;
                check(0, "R3 watchdog", n, 0);
            end else if (t % 3 == 1) begin
                buf_wr_count = 12'(1792 + $urandom_range(0, 255));
                base = ar_total;
                repeat (60) @(negedge clk);
                check(ar_total == base, "R2 no start above limit", ar_total, base);
                check(rready == 0, "R9 rready idle", rready, 0);
            end
        end
        if (!hung) begin
            check(ar_total == NTX * 16, "R3 total bursts", ar_total, NTX * 16);
            check(bursts_done >= NTX * 16 - 1, "R3 total beats", bursts_done, NTX * 16);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule